// File: doc/BRIEF.md
# Ternary Flow Classifier

This block sorts packets into flows. An upstream parser hands it a 112-bit header key and 16 payload match bits for each packet. The two are joined into one 128-bit search key, with the header in bits 127:16 and the payload bits in bits 15:0. That key is compared at once against every row of a small ternary table. Each row holds a value, a per-bit care mask, a 16-bit flow identifier and a valid flag. When more than one row matches, the row with the lowest index wins, and its flow identifier is returned one cycle after the lookup strobe.

Rows are loaded through a single write port. In one cycle it sets a row's value, mask, flow identifier and valid flag. Writing a row with the valid flag low takes it out of the search. The table depth and the field widths are constants in the shared package.

Top module: `flow_classifier`

## Requirements
- R1: While reset is high, and in the first cycle after it, `res_valid`, `res_hit` and `res_flow` are 0. Every row is invalid after reset, so a lookup made before any write misses.
- R2: A row matches when its valid flag is 1 and, for every bit where its mask is 1, the key bit equals the value bit. Key bits whose mask bit is 0 are ignored.
- R3: When several rows match, the flow identifier of the row with the lowest index is returned.
- R4: When no row matches, `res_hit` is 0 and `res_flow` is 0.
- R5: A row written with `wr_valid` = 0 never matches, whatever its value and mask.
- R6: `res_valid` is 1 in exactly the cycle after `lk_en` was 1. In a cycle after `lk_en` was 0, `res_valid` is 0 and `res_hit` and `res_flow` keep their previous values.
- R7: A write takes effect for lookups strobed in later cycles. A lookup strobed in the same cycle as a write sees the table as it was before that write.
- R8: The payload bits take part in matching. `lk_pay` forms key bits 15:0 and `lk_hdr` forms key bits 127:16, with the same bit positions in `wr_value` and `wr_mask`.
- R9: A valid row with an all-zero mask matches every key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Row write strobe |
| wr_idx | input | 3 | Row index to write |
| wr_value | input | 128 | Compare value for the row (same bit layout as the key) |
| wr_mask | input | 128 | Care mask for the row; 1 = bit compared |
| wr_flow | input | 16 | Flow identifier stored in the row |
| wr_valid | input | 1 | Valid flag stored in the row |
| lk_en | input | 1 | Lookup strobe |
| lk_hdr | input | 112 | Header part of the search key |
| lk_pay | input | 16 | Payload match bits of the search key |
| res_valid | output | 1 | Result present (one cycle after `lk_en`) |
| res_hit | output | 1 | At least one row matched |
| res_flow | output | 16 | Flow identifier of the winning row, 0 on a miss |

## Verification
A row write and a lookup can fall in the same cycle. That is where an off-by-one in table timing would show up. The bench drives both strobes together on one edge: it writes a catch-all row at index 0 while looking up a key that only a higher row matches. The result must carry the old winner, and the next lookup of the same key must return the new row's flow. The behavioural model applies every lookup before the write of the same edge, and it is compared on every clock during a long phase of random mixed writes and lookups, so any overlap is judged the same way.

// File: rtl/cls_pkg.sv
package cls_pkg;
    localparam int HDR_W   = 112;
    localparam int PAY_W   = 16;
    localparam int FLOW_W  = 16;
    localparam int ENTRIES = 8;
    localparam int KEY_W   = HDR_W + PAY_W;
    localparam int IDX_W   = $clog2(ENTRIES);

    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [FLOW_W-1:0] flow_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  valid;
        key_t  value;
        key_t  mask;
        flow_t flow;
    } entry_t;

    // Ternary compare of one row against a key.
    function automatic logic row_matches(entry_t e, key_t k);
        return e.valid && (((k ^ e.value) & e.mask) == '0);
    endfunction
endpackage

// File: rtl/cls_table.sv
module cls_table
    import cls_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  idx_t                  wr_idx,
    input  entry_t                wr_row,
    output entry_t [ENTRIES-1:0]  tbl
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[i] <= '0;
            end else if (wr_en && (wr_idx == idx_t'(i))) begin
                tbl[i] <= wr_row;
            end
        end
    end
endmodule

// File: rtl/cls_match.sv
module cls_match
    import cls_pkg::*;
(
    input  entry_t [ENTRIES-1:0] tbl,
    input  key_t                 key,
    output logic   [ENTRIES-1:0] hit_vec
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = row_matches(tbl[i], key);
    end
endmodule

// File: rtl/cls_prio.sv
module cls_prio
    import cls_pkg::*;
(
    input  logic   [ENTRIES-1:0] hit_vec,
    input  entry_t [ENTRIES-1:0] tbl,
    output logic   [ENTRIES-1:0] grant,
    output logic                 any_hit,
    output flow_t                sel_flow
);
    logic  [ENTRIES:0]   lower_hit;
    flow_t [ENTRIES:0]   flow_acc;

    assign lower_hit[0] = 1'b0;
    assign flow_acc[0]  = '0;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_pe
        assign grant[i]       = hit_vec[i] & ~lower_hit[i];
        assign lower_hit[i+1] = lower_hit[i] | hit_vec[i];
        assign flow_acc[i+1]  = flow_acc[i] | (tbl[i].flow & {FLOW_W{grant[i]}});
    end

    assign any_hit  = lower_hit[ENTRIES];
    assign sel_flow = flow_acc[ENTRIES];
endmodule

// File: rtl/flow_classifier.sv
module flow_classifier
    import cls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_value,
    input  logic [KEY_W-1:0]  wr_mask,
    input  logic [FLOW_W-1:0] wr_flow,
    input  logic              wr_valid,
    input  logic              lk_en,
    input  logic [HDR_W-1:0]  lk_hdr,
    input  logic [PAY_W-1:0]  lk_pay,
    output logic              res_valid,
    output logic              res_hit,
    output logic [FLOW_W-1:0] res_flow
);
    entry_t [ENTRIES-1:0] tbl;
    entry_t               wr_row;
    key_t                 key;
    logic [ENTRIES-1:0]   hit_vec;
    logic [ENTRIES-1:0]   grant;
    logic                 any_hit;
    flow_t                sel_flow;

    always_comb begin
        wr_row.valid = wr_valid;
        wr_row.value = wr_value;
        wr_row.mask  = wr_mask;
        wr_row.flow  = wr_flow;
    end

    assign key = {lk_hdr, lk_pay};

    cls_table u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_row (wr_row),
        .tbl    (tbl)
    );

    cls_match u_match (
        .tbl     (tbl),
        .key     (key),
        .hit_vec (hit_vec)
    );

    cls_prio u_prio (
        .hit_vec  (hit_vec),
        .tbl      (tbl),
        .grant    (grant),
        .any_hit  (any_hit),
        .sel_flow (sel_flow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_flow  <= '0;
        end else begin
            res_valid <= lk_en;
            if (lk_en) begin
                res_hit  <= any_hit;
                res_flow <= sel_flow;
            end
        end
    end
endmodule

// File: rtl/cls_chk.sv
module cls_chk
    import cls_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_en,
    input  logic                 res_valid,
    input  logic                 res_hit,
    input  logic [FLOW_W-1:0]    res_flow,
    input  key_t                 key,
    input  entry_t [ENTRIES-1:0] tbl,
    input  logic   [ENTRIES-1:0] hit_vec,
    input  logic   [ENTRIES-1:0] grant,
    input  flow_t                sel_flow
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_hit && res_flow == '0));

    p_valid_after_lookup_r6: assert property (@(posedge clk) disable iff (rst)
        lk_en |=> res_valid);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !lk_en |=> (!res_valid && $stable(res_hit) && $stable(res_flow)));

    p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_flow == '0));

    p_single_winner_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~hit_vec) == '0) && ((|grant) == (|hit_vec)));

    p_hit_from_old_table_r7: assert property (@(posedge clk) disable iff (rst)
        lk_en |=> (res_hit == $past(|hit_vec)));

    for (genvar i = 0; i < ENTRIES; i++) begin : g_row_chk
        p_row_rule_r2: assert property (@(posedge clk) disable iff (rst)
            hit_vec[i] |-> (tbl[i].valid && (((key ^ tbl[i].value) & tbl[i].mask) == '0)));

        p_winner_flow_r3: assert property (@(posedge clk) disable iff (rst)
            grant[i] |-> (sel_flow == tbl[i].flow));
    end
endmodule

bind flow_classifier cls_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_en     (lk_en),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_flow  (res_flow),
    .key       (key),
    .tbl       (tbl),
    .hit_vec   (hit_vec),
    .grant     (grant),
    .sel_flow  (sel_flow)
);

// File: tb/flow_classifier_test.sv
`timescale 1ns/1ps
module flow_classifier_test;
    import cls_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [KEY_W-1:0]  wr_value = '0;
    logic [KEY_W-1:0]  wr_mask = '0;
    logic [FLOW_W-1:0] wr_flow = '0;
    logic              wr_valid = 1'b0;
    logic              lk_en = 1'b0;
    logic [HDR_W-1:0]  lk_hdr = '0;
    logic [PAY_W-1:0]  lk_pay = '0;
    logic              res_valid;
    logic              res_hit;
    logic [FLOW_W-1:0] res_flow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    flow_classifier uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_value(wr_value), .wr_mask(wr_mask),
        .wr_flow(wr_flow), .wr_valid(wr_valid),
        .lk_en(lk_en), .lk_hdr(lk_hdr), .lk_pay(lk_pay),
        .res_valid(res_valid), .res_hit(res_hit), .res_flow(res_flow)
    );

    // Behavioural reference: lookup on an edge uses rows as they stood before that edge's write.
    logic  m_v   [ENTRIES];
    key_t  m_val [ENTRIES];
    key_t  m_msk [ENTRIES];
    flow_t m_fl  [ENTRIES];
    logic  e_valid = 1'b0;
    logic  e_hit   = 1'b0;
    flow_t e_flow  = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                m_v[i] = 1'b0; m_val[i] = '0; m_msk[i] = '0; m_fl[i] = '0;
            end
            e_valid = 1'b0; e_hit = 1'b0; e_flow = '0;
        end else begin
            if (lk_en) begin
                key_t k;
                k = {lk_hdr, lk_pay};
                e_hit = 1'b0;
                e_flow = '0;
                for (int i = ENTRIES - 1; i >= 0; i--) begin
                    if (m_v[i] && (((k ^ m_val[i]) & m_msk[i]) == '0)) begin
                        e_hit = 1'b1;
                        e_flow = m_fl[i];
                    end
                end
            end
            e_valid = lk_en;
            if (wr_en) begin
                m_v[wr_idx] = wr_valid; m_val[wr_idx] = wr_value;
                m_msk[wr_idx] = wr_mask; m_fl[wr_idx] = wr_flow;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model (R6 timing, all rules via model).
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R6 model res_valid", 32'(res_valid), 32'(e_valid));
            check("R2 model res_hit",   32'(res_hit),   32'(e_hit));
            check("R3 model res_flow",  32'(res_flow),  32'(e_flow));
        end
    end

    task automatic wr(input int idx, input key_t v, input key_t m, input flow_t f, input logic vld);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_value = v; wr_mask = m;
        wr_flow = f; wr_valid = vld;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input key_t k);
        @(negedge clk);
        lk_en = 1'b1; lk_hdr = k[KEY_W-1:PAY_W]; lk_pay = k[PAY_W-1:0];
        @(negedge clk);
        lk_en = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic h, input flow_t f);
        check(req, 32'(res_valid), 32'd1);
        check(req, 32'(res_hit), 32'(h));
        check(req, 32'(res_flow), 32'(f));
    endtask

    function automatic key_t small_key();
        key_t k = '0;
        k[KEY_W-1 -: 3] = 3'($urandom);
        k[2:0] = 3'($urandom);
        return k;
    endfunction

    localparam key_t ONES = '1;

    initial begin
        key_t base;
        key_t src_only;
        base = {32'hC0A8_0001, 32'h0A00_0002, 16'd1234, 16'd80, 8'd6, 8'h00, 16'h1234};
        src_only = '0;
        src_only[KEY_W-1 -: 32] = '1;

        repeat (3) @(negedge clk);
        check("R1 reset res_valid", 32'(res_valid), 32'd0);
        check("R1 reset res_hit", 32'(res_hit), 32'd0);
        check("R1 reset res_flow", 32'(res_flow), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset res_valid", 32'(res_valid), 32'd0);
        look(base);
        expect_res("R1 empty table misses", 1'b0, '0);

        wr(3, base, ONES, 16'h0303, 1'b1);
        look(base);
        expect_res("R2 exact match", 1'b1, 16'h0303);
        look(base ^ (key_t'(1) << 40));
        expect_res("R4 one bit off misses", 1'b0, '0);

        wr(5, base, src_only, 16'h0505, 1'b1);
        look(base);
        expect_res("R3 lowest index wins", 1'b1, 16'h0303);
        look(base ^ (key_t'(1) << 20) ^ key_t'(16'hFFFF));
        expect_res("R2 masked bits ignored", 1'b1, 16'h0505);

        wr(2, key_t'(16'hBEEF), key_t'(16'hFFFF), 16'h0202, 1'b1);
        look(key_t'(16'hBEEF));
        expect_res("R8 payload match", 1'b1, 16'h0202);
        look(key_t'(16'hBEEE));
        expect_res("R8 payload mismatch", 1'b0, '0);

        wr(7, '0, '0, 16'h0707, 1'b1);
        look({112'h5A5A, 16'h0001});
        expect_res("R9 zero mask catches all", 1'b1, 16'h0707);

        wr(3, base, ONES, 16'h0303, 1'b0);
        look(base);
        expect_res("R5 cleared row skipped", 1'b1, 16'h0505);

        // R7: write row 0 (catch-all) in the same cycle as a lookup.
        @(negedge clk);
        wr_en = 1'b1; wr_idx = '0; wr_value = '0; wr_mask = '0;
        wr_flow = 16'h0A0A; wr_valid = 1'b1;
        lk_en = 1'b1; lk_hdr = 112'h77; lk_pay = 16'h0;
        @(negedge clk);
        wr_en = 1'b0; lk_en = 1'b0;
        expect_res("R7 same-cycle lookup sees old table", 1'b1, 16'h0707);
        look({112'h77, 16'h0});
        expect_res("R7 write visible afterwards", 1'b1, 16'h0A0A);

        repeat (2) @(negedge clk);
        check("R6 idle res_valid low", 32'(res_valid), 32'd0);
        check("R6 idle hit held", 32'(res_hit), 32'd1);
        check("R6 idle flow held", 32'(res_flow), 32'h0A0A);

        // Random mixed traffic, judged by the per-clock model comparison.
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            wr_en = ($urandom % 4) == 0;
            wr_idx = IDX_W'($urandom);
            wr_value = small_key();
            wr_mask = {$urandom, $urandom, $urandom, $urandom};
            wr_flow = 16'($urandom);
            wr_valid = ($urandom % 5) != 0;
            lk_en = ($urandom % 2) == 0;
            {lk_hdr, lk_pay} = small_key();
        end
        @(negedge clk);
        wr_en = 1'b0; lk_en = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        done = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule